// File: doc/BRIEF.md
# Adaptive-Threshold Locking Crossbar Scheduler

This block computes the crossbar configuration for an N by N input-queued switch in which every input holds a separate queue for each output. On each cell-time strobe it reads, for every input/output pair, how many cells that queue holds and how long its oldest cell has waited. From these it produces a set of input-to-output connections in which no input and no output appears twice.

Pairs that are not held over from an earlier cell time compete in a single round-robin request, grant and accept pass. When a pair chosen by that pass has a backlog or a head-cell age above the current limits, it is pinned. It is then connected directly, with no arbitration, on every later strobe until its queue drains or both of its metrics fall back to the limits. The two limits are recomputed on every strobe as the mean of the corresponding metric over all occupied queues. This gives heavily loaded flows a stable path through the fabric while lightly loaded ports keep fair rotation.

Top module: `adaptive_lock_sched`

## Requirements
- R1: After reset every match_valid bit is 0, lock_map is all 0, and both len_thresh and age_thresh read 1.
- R2: All outputs change only in the clock cycle after a cycle in which cell_tick is 1. Metric changes without a strobe leave every output unchanged.
- R3: Pair (input i, output o) uses the field at flat index i*N+o in voq_len and voq_age. A pair requests only when its length is non-zero. Each strobe yields at most one output per input and at most one input per output. match_out field i (bits i*IW upward) gives the output connected to input i when match_valid[i] is 1.
- R4: Each output grants the first requesting input at or after its grant pointer, in ascending order with wrap. The pointer moves to one past the granted input only when that grant is accepted, and otherwise stays where it is.
- R5: Each input accepts the first offering output at or after its accept pointer, in ascending order with wrap. On acceptance the pointer moves to one past the accepted output.
- R6: A pair connected by arbitration becomes pinned (lock_map bit i*N+o set) when its length is strictly above len_thresh or its age is strictly above age_thresh. Both comparisons use the limits in force before the strobe.
- R7: A pinned pair that stays pinned is connected directly. Its input and output are withdrawn from arbitration, so no other request to either of them is served.
- R8: A pinned pair is released at a strobe when its length is 0, or when its length and its age are both at or below their limits. Its ports then take part in arbitration at that same strobe.
- R9: At each strobe each limit becomes the floor of the mean of its metric over queues with non-zero length, clamped to at least 1. When no queue is occupied, the limit becomes 1. The new limits apply from the next strobe.
- R10: Averaging never wraps: with every length and age at its maximum code, both limits become the maximum code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_tick | input | 1 | One-cycle strobe marking a cell-time boundary |
| voq_len | input | N*N*LEN_W | Queue length per pair, field i*N+o |
| voq_age | input | N*N*AGE_W | Head-cell wait time per pair, field i*N+o |
| match_valid | output | N | Input i has a connection this cell time |
| match_out | output | N*IW | Output index connected to each input |
| lock_map | output | N*N | Pinned state per pair, bit i*N+o |
| len_thresh | output | LEN_W | Current queue-length limit |
| age_thresh | output | AGE_W | Current wait-time limit |

## Verification
The hardest situation to reach is a pinned pair that outlives a change in the limits. That pair's queue has to exceed limits which were themselves derived from its own earlier backlog, while other queues try to reach its input and output. The stimulus first pins a pair against the reset limits of 1. It then raises that queue while adding competing queues on the same input and the same output, so the held connection must win both. Later strobes lower only the length, keeping the age high, and then empty the queue. This separates release on either condition from release on both conditions.

// File: rtl/alsched_pkg.sv
package alsched_pkg;

    // Next position on a ring of n slots.
    function automatic int ring_next(int idx, int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/alsched_rr_pick.sv
// Picks the first asserted request at or after a rotating start position.
module alsched_rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          hit,
    output logic [IW-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (!hit && req[(int'(ptr) + k) % N]) begin
                hit = 1'b1;
                idx = IW'((int'(ptr) + k) % N);
            end
        end
    end

endmodule

// File: rtl/alsched_avg.sv
// Floor mean of the selected entries, never below 1, 1 when none selected.
module alsched_avg #(
    parameter int CNT = 16,
    parameter int W   = 8
) (
    input  logic [CNT*W-1:0] vals,
    input  logic [CNT-1:0]   live,
    output logic [W-1:0]     avg
);

    localparam int CW = $clog2(CNT + 1);
    localparam int SW = W + CW;

    logic [SW-1:0] sum;
    logic [CW-1:0] cnt;
    logic [SW-1:0] quo;

    always_comb begin
        sum = '0;
        cnt = '0;
        for (int k = 0; k < CNT; k++) begin
            if (live[k]) begin
                sum = sum + SW'(vals[k*W +: W]);
                cnt = cnt + CW'(1);
            end
        end
        quo = (cnt == '0) ? SW'(1) : sum / SW'(cnt);
        if (quo == '0)
            avg = W'(1);
        else if (quo > SW'({W{1'b1}}))
            avg = '1;
        else
            avg = quo[W-1:0];
    end

endmodule

// File: rtl/adaptive_lock_sched.sv
module adaptive_lock_sched
    import alsched_pkg::*;
#(
    parameter int N     = 4,
    parameter int LEN_W = 8,
    parameter int AGE_W = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int P  = N * N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cell_tick,
    input  logic [P*LEN_W-1:0] voq_len,
    input  logic [P*AGE_W-1:0] voq_age,
    output logic [N-1:0]       match_valid,
    output logic [N*IW-1:0]    match_out,
    output logic [P-1:0]       lock_map,
    output logic [LEN_W-1:0]   len_thresh,
    output logic [AGE_W-1:0]   age_thresh
);

    typedef struct packed {
        logic [P-1:0]          lock;
        logic [N-1:0][IW-1:0]  gptr;
        logic [N-1:0][IW-1:0]  aptr;
        logic [LEN_W-1:0]      thr_len;
        logic [AGE_W-1:0]      thr_age;
        logic [N-1:0]          mvalid;
        logic [N-1:0][IW-1:0]  mout;
    } sched_t;

    sched_t st_q, st_d;

    logic [P-1:0]         occupied;
    logic [P-1:0]         over_lim;
    logic [P-1:0]         held;
    logic [P-1:0]         req;
    logic [N-1:0]         in_busy;
    logic [N-1:0]         out_busy;
    logic [N-1:0]         gnt_hit;
    logic [N-1:0][IW-1:0] gnt_idx;
    logic [N-1:0]         acc_hit;
    logic [N-1:0][IW-1:0] acc_idx;
    logic [LEN_W-1:0]     avg_len;
    logic [AGE_W-1:0]     avg_age;

    // Per-pair metric decode against the limits in force.
    for (genvar p = 0; p < P; p++) begin : g_pair
        logic [LEN_W-1:0] l;
        logic [AGE_W-1:0] a;
        assign l           = voq_len[p*LEN_W +: LEN_W];
        assign a           = voq_age[p*AGE_W +: AGE_W];
        assign occupied[p] = |l;
        assign over_lim[p] = (l > st_q.thr_len) || (a > st_q.thr_age);
        assign held[p]     = st_q.lock[p] && occupied[p] && over_lim[p];
        assign req[p]      = occupied[p] && !in_busy[p / N] && !out_busy[p % N];
    end

    for (genvar i = 0; i < N; i++) begin : g_in_busy
        assign in_busy[i] = |held[i*N +: N];
    end

    // Grant stage: one arbiter per output over the requesting inputs.
    for (genvar o = 0; o < N; o++) begin : g_out
        logic [N-1:0] col_req;
        logic [N-1:0] col_held;
        for (genvar i = 0; i < N; i++) begin : g_col
            assign col_req[i]  = req[i*N + o];
            assign col_held[i] = held[i*N + o];
        end
        assign out_busy[o] = |col_held;
        alsched_rr_pick #(.N(N)) u_grant (
            .req (col_req),
            .ptr (st_q.gptr[o]),
            .hit (gnt_hit[o]),
            .idx (gnt_idx[o])
        );
    end

    // Accept stage: one arbiter per input over the outputs that granted it.
    for (genvar i = 0; i < N; i++) begin : g_acc
        logic [N-1:0] offer;
        for (genvar o = 0; o < N; o++) begin : g_off
            assign offer[o] = gnt_hit[o] && (gnt_idx[o] == IW'(i));
        end
        alsched_rr_pick #(.N(N)) u_accept (
            .req (offer),
            .ptr (st_q.aptr[i]),
            .hit (acc_hit[i]),
            .idx (acc_idx[i])
        );
    end

    alsched_avg #(.CNT(P), .W(LEN_W)) u_avg_len (
        .vals (voq_len),
        .live (occupied),
        .avg  (avg_len)
    );

    alsched_avg #(.CNT(P), .W(AGE_W)) u_avg_age (
        .vals (voq_age),
        .live (occupied),
        .avg  (avg_age)
    );

    always_comb begin
        st_d = st_q;
        if (cell_tick) begin
            st_d.lock    = held;
            st_d.mvalid  = '0;
            st_d.mout    = '0;
            st_d.thr_len = avg_len;
            st_d.thr_age = avg_age;
            // Pinned pairs bypass arbitration.
            for (int i = 0; i < N; i++) begin
                for (int o = 0; o < N; o++) begin
                    if (held[i*N + o]) begin
                        st_d.mvalid[i] = 1'b1;
                        st_d.mout[i]   = IW'(o);
                    end
                end
            end
            // Pairs won in arbitration; pointers move only on acceptance.
            for (int i = 0; i < N; i++) begin
                if (acc_hit[i]) begin
                    st_d.mvalid[i]          = 1'b1;
                    st_d.mout[i]            = acc_idx[i];
                    st_d.aptr[i]            = IW'(ring_next(int'(acc_idx[i]), N));
                    st_d.gptr[acc_idx[i]]   = IW'(ring_next(i, N));
                    if (over_lim[i*N + int'(acc_idx[i])])
                        st_d.lock[i*N + int'(acc_idx[i])] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.thr_len <= LEN_W'(1);
            st_q.thr_age <= AGE_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign match_valid = st_q.mvalid;
    assign match_out   = st_q.mout;
    assign lock_map    = st_q.lock;
    assign len_thresh  = st_q.thr_len;
    assign age_thresh  = st_q.thr_age;

endmodule

// File: rtl/alsched_chk.sv
module alsched_chk #(
    parameter int N     = 4,
    parameter int LEN_W = 8,
    parameter int AGE_W = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int P  = N * N
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cell_tick,
    input logic [N-1:0]     match_valid,
    input logic [N*IW-1:0]  match_out,
    input logic [P-1:0]     lock_map,
    input logic [LEN_W-1:0] len_thresh,
    input logic [AGE_W-1:0] age_thresh
);

    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++)
                if (match_valid[a] && match_valid[b] &&
                    match_out[a*IW +: IW] == match_out[b*IW +: IW])
                    dup = 1'b1;
    end

    // R3
    no_shared_output_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);

    // R2
    quiet_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cell_tick) |-> ($stable(match_valid) && $stable(match_out) &&
                               $stable(lock_map) && $stable(len_thresh) && $stable(age_thresh)));

    // R9
    limits_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (len_thresh != '0) && (age_thresh != '0));

    for (genvar i = 0; i < N; i++) begin : g_row
        logic [N-1:0] col;
        for (genvar k = 0; k < N; k++) begin : g_c
            assign col[k] = lock_map[k*N + i];
        end
        // R7
        one_pin_per_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(lock_map[i*N +: N]));
        // R7
        one_pin_per_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
    end

    for (genvar p = 0; p < P; p++) begin : g_pin
        // R6
        pin_is_connected_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lock_map[p] |-> (match_valid[p / N] &&
                             match_out[(p / N)*IW +: IW] == IW'(p % N)));
    end

endmodule

bind adaptive_lock_sched alsched_chk #(.N(N), .LEN_W(LEN_W), .AGE_W(AGE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cell_tick   (cell_tick),
    .match_valid (match_valid),
    .match_out   (match_out),
    .lock_map    (lock_map),
    .len_thresh  (len_thresh),
    .age_thresh  (age_thresh)
);

// File: tb/adaptive_lock_sched_test.sv
module adaptive_lock_sched_test;

    localparam int N  = 4;
    localparam int LW = 8;
    localparam int AW = 8;
    localparam int IW = 2;
    localparam int P  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cell_tick = 1'b0;
    logic [P*LW-1:0] voq_len = '0;
    logic [P*AW-1:0] voq_age = '0;
    logic [N-1:0]    match_valid;
    logic [N*IW-1:0] match_out;
    logic [P-1:0]    lock_map;
    logic [LW-1:0]   len_thresh;
    logic [AW-1:0]   age_thresh;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    adaptive_lock_sched #(.N(N), .LEN_W(LW), .AGE_W(AW)) uut (
        .clk, .rst_n, .cell_tick, .voq_len, .voq_age,
        .match_valid, .match_out, .lock_map, .len_thresh, .age_thresh
    );

    task automatic expect_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_voq();
        voq_len = '0;
        voq_age = '0;
    endtask

    task automatic set_voq(int i, int o, int l, int a);
        voq_len[(i*N+o)*LW +: LW] = LW'(l);
        voq_age[(i*N+o)*AW +: AW] = AW'(a);
    endtask

    task automatic tick();
        @(negedge clk);
        cell_tick = 1'b1;
        @(negedge clk);
        cell_tick = 1'b0;
    endtask

    task automatic expect_state(string tag, logic [N-1:0] v, int o0, int o1, int o2, int o3,
                                logic [P-1:0] lk, int tl, int ta);
        int outs[4];
        outs = '{o0, o1, o2, o3};
        expect_eq({tag, " valid"}, int'(match_valid), int'(v));
        for (int i = 0; i < N; i++)
            if (v[i]) expect_eq($sformatf("%s out%0d", tag, i), int'(match_out[i*IW +: IW]), outs[i]);
        expect_eq({tag, " lock"}, int'(lock_map), int'(lk));
        expect_eq({tag, " len_thr"}, int'(len_thresh), tl);
        expect_eq({tag, " age_thr"}, int'(age_thresh), ta);
    endtask

    task automatic test_reset();
        expect_state("R1 reset", 4'b0000, 0, 0, 0, 0, 16'h0000, 1, 1);
    endtask

    task automatic test_no_tick();
        clear_voq();
        set_voq(0, 0, 7, 7);
        repeat (3) @(negedge clk);
        expect_state("R2 no strobe", 4'b0000, 0, 0, 0, 0, 16'h0000, 1, 1);
        clear_voq();
        tick();
        expect_state("R9 all empty", 4'b0000, 0, 0, 0, 0, 16'h0000, 1, 1);
    endtask

    task automatic test_grant_rotation();
        clear_voq(); set_voq(1, 2, 1, 1); tick();
        expect_state("R3 single pair", 4'b0010, 0, 2, 0, 0, 16'h0000, 1, 1);
        clear_voq(); set_voq(1, 2, 1, 1); set_voq(3, 2, 1, 1); tick();
        expect_state("R4 grant after pointer", 4'b1000, 0, 0, 0, 2, 16'h0000, 1, 1);
        tick();
        expect_state("R4 grant wraps", 4'b0010, 0, 2, 0, 0, 16'h0000, 1, 1);
    endtask

    task automatic test_accept_rotation();
        clear_voq(); set_voq(0, 1, 1, 1); set_voq(0, 3, 1, 1); tick();
        expect_state("R5 accept first", 4'b0001, 1, 0, 0, 0, 16'h0000, 1, 1);
        tick();
        expect_state("R5 accept rotates", 4'b0001, 3, 0, 0, 0, 16'h0000, 1, 1);
    endtask

    task automatic test_pin_and_hold();
        clear_voq(); set_voq(2, 0, 5, 1); tick();
        expect_state("R6 pin by length", 4'b0100, 0, 0, 0, 0, 16'h0100, 5, 1);
        clear_voq(); set_voq(2, 0, 6, 1); set_voq(0, 0, 1, 1); set_voq(2, 3, 1, 1); tick();
        expect_state("R7 held pair blocks others", 4'b0100, 0, 0, 0, 0, 16'h0100, 2, 1);
        clear_voq(); set_voq(2, 0, 2, 1); tick();
        expect_state("R8 release at limits", 4'b0100, 0, 0, 0, 0, 16'h0000, 2, 1);
    endtask

    task automatic test_age_and_empty();
        clear_voq(); set_voq(3, 1, 1, 9); tick();
        expect_state("R6 pin by age", 4'b1000, 0, 0, 0, 1, 16'h2000, 1, 9);
        clear_voq(); set_voq(1, 1, 1, 1); tick();
        expect_state("R8 release on empty", 4'b0010, 0, 1, 0, 0, 16'h0000, 1, 1);
    endtask

    task automatic test_either_keeps();
        clear_voq(); set_voq(0, 2, 3, 1); tick();
        expect_state("R6 pin again", 4'b0001, 2, 0, 0, 0, 16'h0004, 3, 1);
        clear_voq(); set_voq(0, 2, 1, 4); set_voq(1, 2, 1, 1); tick();
        expect_state("R8 age alone keeps pin", 4'b0001, 2, 0, 0, 0, 16'h0004, 1, 2);
        clear_voq(); tick();
        expect_state("R9 empty resets limits", 4'b0000, 0, 0, 0, 0, 16'h0000, 1, 1);
    endtask

    task automatic test_saturation();
        int nv, nl;
        voq_len = '1;
        voq_age = '1;
        tick();
        expect_eq("R10 len limit max", int'(len_thresh), 255);
        expect_eq("R10 age limit max", int'(age_thresh), 255);
        nv = $countones(match_valid);
        nl = $countones(lock_map);
        expect_eq("R3 full load connects", int'(nv > 0), 1);
        expect_eq("R6 every winner pinned", nl, nv);
        for (int i = 0; i < N; i++)
            if (match_valid[i])
                expect_eq($sformatf("R6 pin matches input %0d", i),
                          int'(lock_map[i*N + int'(match_out[i*IW +: IW])]), 1);
        tick();
        expect_eq("R8 release at max limits", int'(lock_map), 0);
        expect_eq("R3 reconnect after release", int'(match_valid != 0), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_no_tick();
        test_grant_rotation();
        test_accept_rotation();
        test_pin_and_hold();
        test_age_and_empty();
        test_either_keeps();
        test_saturation();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule